// File: doc/BRIEF.md
# USB OUT Endpoint Control and Status Logic

This block holds the byte-wide control and status register of a single OUT endpoint in a USB device core, together with the transaction state machine that picks the handshake. On one side the MCU reads and writes the register. On the other side the serial interface engine reports two things: the start of an OUT transaction, and the end of the data packet that follows it, with the packet's byte count and data PID. For each data packet the block answers with ACK, NAK or STALL.

The block keeps four pieces of state. It records whether a packet is waiting in the endpoint FIFO for the MCU to unload. It holds the expected DATA0/DATA1 toggle. It tracks a stall forced by the MCU and a flag that records that a STALL handshake was sent. It also keeps the FIFO write and read pointers. The FIFO storage itself sits outside the block; these pointers address it. A flush request discards the pending packet and rewinds both pointers. The request is honoured only while a packet is pending.

The state machine has three states:
- `ST_IDLE` waits for an OUT token.
- `ST_RX` waits for the end of the data packet.
- `ST_HS` presents the handshake for one cycle.

Its transitions are:
- `IDLE->RX`: on a token.
- `RX->RX`: on a repeated token.
- `RX->HS`: at the end of the packet.
- `HS->IDLE`: when no token is present.
- `HS->RX`: when a token arrives back to back.

Top module: `usb_oep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the expected toggle is DATA0, both FIFO pointers are 0 and `hs_valid` is low.
- R2: Read layout: bit 0 = packet pending, bit 5 = forced stall, bit 6 = stall sent. Bits 7, 4 and 3 to 1 always read 0.
- R3: Writing 1 to bit 7 sets the expected toggle to DATA0 (`data_toggle` = 0). If a packet is stored in the same cycle, the toggle clear wins over the flip.
- R4: A packet that meets all of the following is accepted: it ends in `ST_RX`, its count is at most MAXP, there is no forced stall, no packet is pending, and its PID bit equals the expected toggle. The block answers ACK (code 2'b01), sets bit 0, flips the toggle and advances `wr_ptr` by the byte count.
- R5: A packet that would otherwise be accepted but has the wrong PID bit gets ACK. Bit 0, the toggle and `wr_ptr` stay unchanged.
- R6: While bit 0 is set, a data packet without a stall condition gets NAK (code 2'b10). Bit 0, bit 6, the toggle and `wr_ptr` stay unchanged.
- R7: A packet whose count exceeds MAXP gets STALL (code 2'b11) and sets bit 6. Nothing is stored. This check takes priority over NAK and over the toggle check.
- R8: Bit 5 is written directly by the MCU. While it is 1, every data packet gets STALL and sets bit 6. It stays 1 until the MCU writes 0.
- R9: Writing 0 to bit 6 clears it and writing 1 has no effect. If a STALL sets bit 6 in the same cycle as a write of 0, bit 6 ends up 1.
- R10: Writing 0 to bit 0 clears it and writing 1 has no effect. If a store happens in the same cycle, the hardware set wins.
- R11: Writing 1 to bit 4 while bit 0 is set clears bit 0 and zeroes both `wr_ptr` and `rd_ptr` in the next cycle. While bit 0 is clear, the write leaves both pointers unchanged.
- R12: `hs_valid` is high for exactly the one cycle after the packet end is sampled in `ST_RX`. A packet end seen in `ST_IDLE` produces no handshake and changes nothing.
- R13: Each `fifo_rd` pulse advances `rd_ptr` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | MCU register write strobe |
| reg_wdata | input | 8 | MCU write data |
| reg_rdata | output | 8 | Register read value |
| sie_out_tok | input | 1 | OUT token seen, one-cycle pulse |
| sie_pkt_done | input | 1 | Data packet ended, one-cycle pulse |
| sie_pkt_len | input | LEN_W | Byte count of the ended packet |
| sie_pkt_pid1 | input | 1 | Ended packet carried DATA1 |
| fifo_rd | input | 1 | MCU read one byte from the FIFO |
| hs_valid | output | 1 | Handshake code is valid |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| data_toggle | output | 1 | Expected PID toggle of the next packet |
| wr_ptr | output | PTR_W | FIFO write pointer |
| rd_ptr | output | PTR_W | FIFO read pointer |

## Verification
The assertions assume that the engine sends `sie_out_tok` and `sie_pkt_done` as single-cycle pulses. They also assume that `sie_pkt_len` and `sie_pkt_pid1` are valid in the cycle of the packet-end pulse. The bench drives both events from one task, one negedge after another. It raises each pulse for exactly one cycle, so a token and a packet end never share a cycle. MCU writes are presented only as one-cycle strobes. Some writes are deliberately placed in the packet-end cycle to exercise the hardware-wins cases.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_HS   = 2'd2
    } oep_state_t;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_t;

    localparam int BIT_RDY   = 0;
    localparam int BIT_FLUSH = 4;
    localparam int BIT_FSTL  = 5;
    localparam int BIT_SSTL  = 6;
    localparam int BIT_TCLR  = 7;

endpackage

// File: rtl/usb_oep_fsm.sv
module usb_oep_fsm
    import usb_oep_pkg::*;
#(
    parameter int MAXP  = 64,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_tok,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             pkt_pid1,
    input  logic             pkt_rdy,
    input  logic             force_stall,
    input  logic             toggle,
    output logic             ev_store,
    output logic             ev_stall,
    output logic             hs_valid,
    output hs_code_t         hs_code
);

    localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAXP);

    oep_state_t state, state_n;
    hs_code_t   code_q, code_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (out_tok) state_n = ST_RX;
            ST_RX:   if (pkt_done) state_n = ST_HS;
            ST_HS:   state_n = out_tok ? ST_RX : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            code_q <= HS_NONE;
        end else begin
            state  <= state_n;
            code_q <= code_n;
        end
    end

    always_comb begin
        ev_store = 1'b0;
        ev_stall = 1'b0;
        code_n   = code_q;
        hs_valid = (state == ST_HS);
        hs_code  = hs_valid ? code_q : HS_NONE;
        if (state == ST_RX && pkt_done) begin
            if (force_stall || pkt_len > MAXP_L) begin
                code_n   = HS_STALL;
                ev_stall = 1'b1;
            end else if (pkt_rdy) begin
                code_n = HS_NAK;
            end else begin
                code_n   = HS_ACK;
                ev_store = (pkt_pid1 == toggle);
            end
        end
    end

    AST_HS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid) else $error("handshake longer than one cycle"); // R12

    AST_STALL_GIVES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall |=> (hs_valid && hs_code == HS_STALL)) else $error("stall event without STALL"); // R7

endmodule

// File: rtl/usb_oep_csr.sv
module usb_oep_csr
    import usb_oep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       ev_store,
    input  logic       ev_stall,
    output logic       pkt_rdy,
    output logic       force_stall,
    output logic       sent_stall,
    output logic       toggle,
    output logic       flush,
    output logic [7:0] rdata
);

    logic clr_rdy, clr_sent, clr_tog;

    assign clr_rdy  = reg_wr && !reg_wdata[BIT_RDY];
    assign clr_sent = reg_wr && !reg_wdata[BIT_SSTL];
    assign clr_tog  = reg_wr && reg_wdata[BIT_TCLR];
    assign flush    = reg_wr && reg_wdata[BIT_FLUSH] && pkt_rdy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_rdy     <= 1'b0;
            force_stall <= 1'b0;
            sent_stall  <= 1'b0;
            toggle      <= 1'b0;
        end else begin
            if (ev_store)                pkt_rdy <= 1'b1;
            else if (flush || clr_rdy)   pkt_rdy <= 1'b0;
            if (ev_stall)                sent_stall <= 1'b1;
            else if (clr_sent)           sent_stall <= 1'b0;
            if (reg_wr)                  force_stall <= reg_wdata[BIT_FSTL];
            if (clr_tog)                 toggle <= 1'b0;
            else if (ev_store)           toggle <= !toggle;
        end
    end

    always_comb begin
        rdata           = 8'h00;
        rdata[BIT_RDY]  = pkt_rdy;
        rdata[BIT_FSTL] = force_stall;
        rdata[BIT_SSTL] = sent_stall;
    end

    AST_NO_STORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_store |-> !pkt_rdy) else $error("store while packet pending"); // R6

    AST_STALL_SETS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall |=> sent_stall) else $error("stall not recorded"); // R9

    AST_RDY_ONLY_BY_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_rdy && !ev_store) |=> !pkt_rdy) else $error("pending bit set without store"); // R10

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_store && !clr_tog) |=> (toggle != $past(toggle))) else $error("toggle did not flip"); // R4

endmodule

// File: rtl/usb_oep_ptr.sv
module usb_oep_ptr #(
    parameter int LEN_W = 8,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic [LEN_W-1:0] len,
    input  logic             rd,
    input  logic             flush,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (store) wr_ptr <= wr_ptr + PTR_W'(len);
            if (rd)    rd_ptr <= rd_ptr + 1'b1;
        end
    end

    AST_FLUSH_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wr_ptr == '0 && rd_ptr == '0)) else $error("flush left pointers"); // R11

endmodule

// File: rtl/usb_oep_ctrl.sv
module usb_oep_ctrl
    import usb_oep_pkg::*;
#(
    parameter int MAXP       = 64,
    parameter int LEN_W      = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int PTR_W      = $clog2(FIFO_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             sie_out_tok,
    input  logic             sie_pkt_done,
    input  logic [LEN_W-1:0] sie_pkt_len,
    input  logic             sie_pkt_pid1,
    input  logic             fifo_rd,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             data_toggle,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);

    logic     ev_store, ev_stall, pkt_rdy, force_stall, sent_stall, toggle, flush;
    hs_code_t code;

    usb_oep_fsm #(.MAXP(MAXP), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .out_tok(sie_out_tok), .pkt_done(sie_pkt_done),
        .pkt_len(sie_pkt_len), .pkt_pid1(sie_pkt_pid1),
        .pkt_rdy(pkt_rdy), .force_stall(force_stall), .toggle(toggle),
        .ev_store(ev_store), .ev_stall(ev_stall),
        .hs_valid(hs_valid), .hs_code(code)
    );

    usb_oep_csr u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ev_store(ev_store), .ev_stall(ev_stall),
        .pkt_rdy(pkt_rdy), .force_stall(force_stall), .sent_stall(sent_stall),
        .toggle(toggle), .flush(flush), .rdata(reg_rdata)
    );

    usb_oep_ptr #(.LEN_W(LEN_W), .PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .store(ev_store), .len(sie_pkt_len), .rd(fifo_rd), .flush(flush),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    assign hs_code     = code;
    assign data_toggle = toggle;

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] == 1'b0 && reg_rdata[4:1] == 4'b0)) else $error("reserved bit set"); // R2

endmodule

// File: tb/tb_usb_oep_ctrl.sv
module tb_usb_oep_ctrl;

    localparam int LEN_W = 8;
    localparam int PTR_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [7:0]       reg_rdata;
    logic             sie_out_tok = 1'b0;
    logic             sie_pkt_done = 1'b0;
    logic [LEN_W-1:0] sie_pkt_len = '0;
    logic             sie_pkt_pid1 = 1'b0;
    logic             fifo_rd = 1'b0;
    logic             hs_valid;
    logic [1:0]       hs_code;
    logic             data_toggle;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    usb_oep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sie_out_tok(sie_out_tok), .sie_pkt_done(sie_pkt_done),
        .sie_pkt_len(sie_pkt_len), .sie_pkt_pid1(sie_pkt_pid1), .fifo_rd(fifo_rd),
        .hs_valid(hs_valid), .hs_code(hs_code), .data_toggle(data_toggle),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    // vector: [23:22] op (0 transaction, 1 register write), [21:14] len or wdata,
    // [13] pid1, [12:11] expected code (0 = do not check), [10:3] expected rdata, [2] expected toggle
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 8'd10,  1'b0, 2'd1, 8'h01, 1'b1, 2'b0}, // R4 accept
        {2'd0, 8'd5,   1'b0, 2'd2, 8'h01, 1'b1, 2'b0}, // R6 NAK while pending
        {2'd1, 8'h00,  1'b0, 2'd0, 8'h00, 1'b1, 2'b0}, // R10 clear pending
        {2'd0, 8'd8,   1'b0, 2'd1, 8'h00, 1'b1, 2'b0}, // R5 wrong toggle
        {2'd0, 8'd8,   1'b1, 2'd1, 8'h01, 1'b0, 2'b0}, // R4 DATA1 accept
        {2'd1, 8'h00,  1'b0, 2'd0, 8'h00, 1'b0, 2'b0}, // R10
        {2'd0, 8'd65,  1'b0, 2'd3, 8'h40, 1'b0, 2'b0}, // R7 oversize
        {2'd1, 8'h00,  1'b0, 2'd0, 8'h00, 1'b0, 2'b0}, // R9 clear sent
        {2'd1, 8'h20,  1'b0, 2'd0, 8'h20, 1'b0, 2'b0}, // R8 force stall
        {2'd0, 8'd4,   1'b0, 2'd3, 8'h60, 1'b0, 2'b0}, // R8 forced STALL
        {2'd1, 8'h00,  1'b0, 2'd0, 8'h00, 1'b0, 2'b0}, // R8 end stall
        {2'd0, 8'd64,  1'b0, 2'd1, 8'h01, 1'b1, 2'b0}, // R4 exactly MAXP
        {2'd1, 8'h81,  1'b0, 2'd0, 8'h01, 1'b0, 2'b0}, // R3 toggle clear, R2 bit7 reads 0
        {2'd1, 8'h41,  1'b0, 2'd0, 8'h01, 1'b0, 2'b0}  // R9 write 1 no effect
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    // token, then packet end; optional MCU write in the packet-end cycle
    task automatic txn(input int len, input bit pid, input bit wr, input logic [7:0] wd,
                       output logic [1:0] code);
        @(negedge clk);
        sie_out_tok = 1'b1;
        @(negedge clk);
        sie_out_tok = 1'b0;
        sie_pkt_done = 1'b1; sie_pkt_len = LEN_W'(len); sie_pkt_pid1 = pid;
        reg_wr = wr; reg_wdata = wd;
        @(negedge clk);
        sie_pkt_done = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        code = hs_valid ? hs_code : 2'b00;
        chk(hs_valid === 1'b1, "R12 hs_valid after packet", int'(hs_valid), 1);
        @(negedge clk);
        chk(hs_valid === 1'b0, "R12 hs_valid one cycle", int'(hs_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0] code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata === 8'h00, "R1 reset rdata", int'(reg_rdata), 0);
        chk(data_toggle === 1'b0, "R1 reset toggle", int'(data_toggle), 0);
        chk(wr_ptr === '0 && rd_ptr === '0, "R1 reset pointers", int'(wr_ptr), 0);
        chk(hs_valid === 1'b0, "R1 reset hs_valid", int'(hs_valid), 0);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            if (v[23:22] == 2'd0) begin
                txn(int'(v[21:14]), v[13], 1'b0, 8'h00, code);
                chk(code === v[12:11], "R4-R8 vector handshake", int'(code), int'(v[12:11]));
            end else begin
                reg_write(v[21:14]);
            end
            chk(reg_rdata === v[10:3], "R2 vector rdata", int'(reg_rdata), int'(v[10:3]));
            chk(data_toggle === v[2], "R3 vector toggle", int'(data_toggle), int'(v[2]));
        end
        chk(wr_ptr === 7'd82, "R4 write pointer sum", int'(wr_ptr), 82);

        // R13 read pointer
        repeat (3) begin
            @(negedge clk); fifo_rd = 1'b1;
        end
        @(negedge clk); fifo_rd = 1'b0;
        chk(rd_ptr === 7'd3, "R13 rd_ptr", int'(rd_ptr), 3);

        // R11 flush while pending
        reg_write(8'h11);
        chk(reg_rdata === 8'h00, "R11 flush clears pending", int'(reg_rdata), 0);
        chk(wr_ptr === '0 && rd_ptr === '0, "R11 flush pointers", int'(wr_ptr) + int'(rd_ptr), 0);

        // R11 flush ignored when nothing pending
        txn(6, 1'b0, 1'b0, 8'h00, code);
        chk(code === 2'b01 && wr_ptr === 7'd6, "R4 store after flush", int'(wr_ptr), 6);
        reg_write(8'h00);
        reg_write(8'h10);
        chk(wr_ptr === 7'd6, "R11 flush ignored", int'(wr_ptr), 6);

        // R10 write 1 to bit 0 has no effect
        reg_write(8'h01);
        chk(reg_rdata === 8'h00, "R10 write one ignored", int'(reg_rdata), 0);

        // R12 packet end in idle ignored
        @(negedge clk);
        sie_pkt_done = 1'b1; sie_pkt_len = 8'd3; sie_pkt_pid1 = 1'b1;
        @(negedge clk);
        sie_pkt_done = 1'b0;
        chk(hs_valid === 1'b0, "R12 idle packet end", int'(hs_valid), 0);
        chk(reg_rdata === 8'h00 && wr_ptr === 7'd6, "R12 idle no change", int'(reg_rdata), 0);

        // R9 hardware set wins over clearing write
        txn(100, 1'b1, 1'b1, 8'h00, code);
        chk(code === 2'b11, "R7 oversize stall", int'(code), 3);
        chk(reg_rdata === 8'h40, "R9 hw set wins", int'(reg_rdata), 'h40);
        reg_write(8'h00);

        // R3 toggle clear wins over flip; R10 store wins over clear
        txn(2, 1'b1, 1'b1, 8'h80, code);
        chk(code === 2'b01, "R4 accept DATA1", int'(code), 1);
        chk(data_toggle === 1'b0, "R3 clear wins", int'(data_toggle), 0);
        chk(reg_rdata === 8'h01, "R10 store wins", int'(reg_rdata), 1);
        chk(wr_ptr === 7'd8, "R4 pointer advance", int'(wr_ptr), 8);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule